// File: doc/BRIEF.md
# Address Fault Trap Detector

This block screens every memory reference a processor core makes and raises a trap request when the reference breaks the memory map or the alignment rules. It sees each data read, data write, program-space data read and instruction fetch. A request is qualified by a valid strobe, and the verdict appears one clock later as a trap request with a cause code.

Data references are checked for word alignment and against the implemented data range. When the core runs a multiply-accumulate style dual-operand access, one operand comes from the X bank and the other from the Y bank. In that case an X-bank operand whose address falls in the Y bank counts as unimplemented, and so does a Y-bank operand that falls in the X bank. Program-side references are checked against the top of implemented program memory. An instruction fetch that lands in the vector table is also an error. A jump through a vector that holds a target beyond program memory therefore surfaces as a program-unimplemented fault on the following fetch.

All region bounds are parameters, so one design serves every memory size in a product family. The memory arrays themselves lie outside this block.

Top module: `addr_fault_detect`

## Requirements
- R1: While `rst` is high, the outputs clear on the next clock edge: `trap_req` is 0 and `trap_cause` is 0 (none).
- R2: The verdict for a request appears on the outputs one clock after the request is presented with `req_valid` high. A cycle with `req_valid` low gives `trap_req` 0 and `trap_cause` 0 one clock later.
- R3: A data read or data write (`acc_kind` 0 or 1) with `acc_word` 1 and `data_addr[0]` 1 reports cause 1 (misaligned).
- R4: A byte data access (`acc_word` 0) never reports cause 1, whatever its address.
- R5: Outside dual-bank mode (`mac_mode` 0), a data read or write with `data_addr` above DATA_TOP reports cause 2 (data unimplemented). Addresses from 0 to DATA_TOP are accepted.
- R6: With `mac_mode` 1, a data read or write selecting the X bank (`mac_sel_y` 0) whose address lies in [Y_LO, Y_HI] reports cause 2. One selecting the Y bank (`mac_sel_y` 1) whose address lies in [X_LO, X_HI] also reports cause 2. Addresses above DATA_TOP still report cause 2.
- R7: A program-space read (`acc_kind` 2) or an instruction fetch (`acc_kind` 3) with `prog_addr` above PROG_TOP reports cause 3 (program unimplemented). This is how a jump through a vector holding an invalid target is caught.
- R8: An instruction fetch with `prog_addr` in [VEC_LO, VEC_HI] reports cause 4 (vector fetch). A program-space read of the same addresses reports no fault.
- R9: When several conditions hold at once, the cause is the first in this order: misaligned (1), data unimplemented (2), program unimplemented (3), vector fetch (4).
- R10: `trap_req` is 1 exactly when `trap_cause` is nonzero. `data_addr` has no effect for kinds 2 and 3, and `prog_addr` has no effect for kinds 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A reference is presented this cycle |
| acc_kind | input | 2 | 0 data read, 1 data write, 2 program-space read, 3 instruction fetch |
| acc_word | input | 1 | 1 word access, 0 byte access (data kinds) |
| data_addr | input | DW | Byte address of a data reference |
| mac_mode | input | 1 | Dual-bank multiply-accumulate addressing active |
| mac_sel_y | input | 1 | In dual-bank mode: 0 X bank, 1 Y bank |
| prog_addr | input | PW | Program-space address for kinds 2 and 3 |
| trap_req | output | 1 | Address error trap request |
| trap_cause | output | 3 | 0 none, 1 misaligned, 2 data unimplemented, 3 program unimplemented, 4 vector fetch |

## Verification
The bound checker watches on every cycle that reset and idle cycles leave the outputs quiet and that the trap line tracks a nonzero cause. It also checks that byte accesses never report misalignment, that odd word accesses always do, and that a fetch inside the vector table gets its own cause. The bench's sweep over every address, kind, size and bank selection of a small memory map is what shows the region boundaries exactly. That sweep also covers the dual-bank exclusions, the priority among simultaneous faults, and the fact that each side's address is ignored for the other side's kinds.

// File: rtl/addr_fault_pkg.sv
package addr_fault_pkg;

    typedef enum logic [1:0] {
        KIND_DREAD  = 2'd0,
        KIND_DWRITE = 2'd1,
        KIND_PREAD  = 2'd2,
        KIND_FETCH  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_MISALIGN   = 3'd1,
        CAUSE_DATA_UNIMP = 3'd2,
        CAUSE_PROG_UNIMP = 3'd3,
        CAUSE_VEC_FETCH  = 3'd4
    } fault_cause_e;

    localparam int unsigned NUM_FAULTS = 4;

    // Bit index equals priority rank: bit 0 wins.
    typedef struct packed {
        logic vec_fetch;
        logic prog_unimp;
        logic data_unimp;
        logic misalign;
    } fault_flags_t;

    function automatic logic is_data_kind(acc_kind_e k);
        return (k == KIND_DREAD) || (k == KIND_DWRITE);
    endfunction

    function automatic logic in_window(longint unsigned a,
                                       longint unsigned lo,
                                       longint unsigned hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/afd_data_check.sv
module afd_data_check
    import addr_fault_pkg::*;
#(
    parameter int unsigned     DW       = 16,
    parameter logic [DW-1:0]   DATA_TOP = 16'h1FFF,
    parameter logic [DW-1:0]   X_LO     = 16'h0800,
    parameter logic [DW-1:0]   X_HI     = 16'h17FF,
    parameter logic [DW-1:0]   Y_LO     = 16'h1800,
    parameter logic [DW-1:0]   Y_HI     = 16'h1FFF
) (
    input  acc_kind_e       kind,
    input  logic            word,
    input  logic [DW-1:0]   addr,
    input  logic            mac_mode,
    input  logic            mac_sel_y,
    output logic            misalign,
    output logic            unimp
);
    logic data_ref;
    logic above_top;
    logic in_x;
    logic in_y;
    logic cross_bank;

    always_comb begin
        data_ref   = is_data_kind(kind);
        above_top  = addr > DATA_TOP;
        in_x       = in_window(longint'(addr), longint'(X_LO), longint'(X_HI));
        in_y       = in_window(longint'(addr), longint'(Y_LO), longint'(Y_HI));
        cross_bank = mac_mode && (mac_sel_y ? in_x : in_y);
        misalign   = data_ref && word && addr[0];
        unimp      = data_ref && (above_top || cross_bank);
    end
endmodule

// File: rtl/afd_prog_check.sv
module afd_prog_check
    import addr_fault_pkg::*;
#(
    parameter int unsigned   PW       = 24,
    parameter logic [PW-1:0] PROG_TOP = 24'h015FFF,
    parameter logic [PW-1:0] VEC_LO   = 24'h000004,
    parameter logic [PW-1:0] VEC_HI   = 24'h00007F
) (
    input  acc_kind_e       kind,
    input  logic [PW-1:0]   addr,
    output logic            unimp,
    output logic            vec_hit
);
    logic prog_ref;

    always_comb begin
        prog_ref = (kind == KIND_PREAD) || (kind == KIND_FETCH);
        unimp    = prog_ref && (addr > PROG_TOP);
        vec_hit  = (kind == KIND_FETCH) &&
                   in_window(longint'(addr), longint'(VEC_LO), longint'(VEC_HI));
    end
endmodule

// File: rtl/afd_cause_sel.sv
module afd_cause_sel
    import addr_fault_pkg::*;
(
    input  fault_flags_t  flags,
    output fault_cause_e  cause,
    output logic          any
);
    logic [NUM_FAULTS-1:0] vec;

    always_comb begin
        vec   = flags;
        cause = CAUSE_NONE;
        for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
            if (vec[i]) cause = fault_cause_e'(3'(i + 1));
        end
        any = |vec;
    end
endmodule

// File: rtl/addr_fault_detect.sv
module addr_fault_detect
    import addr_fault_pkg::*;
#(
    parameter int unsigned   DW       = 16,
    parameter int unsigned   PW       = 24,
    parameter logic [DW-1:0] DATA_TOP = 16'h1FFF,
    parameter logic [DW-1:0] X_LO     = 16'h0800,
    parameter logic [DW-1:0] X_HI     = 16'h17FF,
    parameter logic [DW-1:0] Y_LO     = 16'h1800,
    parameter logic [DW-1:0] Y_HI     = 16'h1FFF,
    parameter logic [PW-1:0] PROG_TOP = 24'h015FFF,
    parameter logic [PW-1:0] VEC_LO   = 24'h000004,
    parameter logic [PW-1:0] VEC_HI   = 24'h00007F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      acc_kind,
    input  logic            acc_word,
    input  logic [DW-1:0]   data_addr,
    input  logic            mac_mode,
    input  logic            mac_sel_y,
    input  logic [PW-1:0]   prog_addr,
    output logic            trap_req,
    output logic [2:0]      trap_cause
);
    acc_kind_e    kind;
    fault_flags_t flags;
    fault_cause_e cause_nx;
    logic         any_nx;
    fault_cause_e cause_q;
    logic         trap_q;

    assign kind = acc_kind_e'(acc_kind);

    afd_data_check #(
        .DW(DW), .DATA_TOP(DATA_TOP),
        .X_LO(X_LO), .X_HI(X_HI), .Y_LO(Y_LO), .Y_HI(Y_HI)
    ) u_data (
        .kind      (kind),
        .word      (acc_word),
        .addr      (data_addr),
        .mac_mode  (mac_mode),
        .mac_sel_y (mac_sel_y),
        .misalign  (flags.misalign),
        .unimp     (flags.data_unimp)
    );

    afd_prog_check #(
        .PW(PW), .PROG_TOP(PROG_TOP), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
    ) u_prog (
        .kind    (kind),
        .addr    (prog_addr),
        .unimp   (flags.prog_unimp),
        .vec_hit (flags.vec_fetch)
    );

    afd_cause_sel u_sel (
        .flags (flags),
        .cause (cause_nx),
        .any   (any_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_NONE;
            trap_q  <= 1'b0;
        end else begin
            cause_q <= req_valid ? cause_nx : CAUSE_NONE;
            trap_q  <= req_valid && any_nx;
        end
    end

    assign trap_req   = trap_q;
    assign trap_cause = cause_q;
endmodule

// File: rtl/addr_fault_check.sv
module addr_fault_check #(
    parameter int unsigned   DW     = 16,
    parameter int unsigned   PW     = 24,
    parameter logic [PW-1:0] PROG_TOP = 24'h015FFF,
    parameter logic [PW-1:0] VEC_LO = 24'h000004,
    parameter logic [PW-1:0] VEC_HI = 24'h00007F
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    acc_kind,
    input logic          acc_word,
    input logic [DW-1:0] data_addr,
    input logic [PW-1:0] prog_addr,
    input logic          trap_req,
    input logic [2:0]    trap_cause
);
    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!trap_req && trap_cause == 3'd0));

    // R2
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!trap_req && trap_cause == 3'd0));

    // R3
    p_odd_word_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !acc_kind[1] && acc_word && data_addr[0])
        |=> trap_cause == 3'd1);

    // R4
    p_byte_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !acc_kind[1] && !acc_word) |=> trap_cause != 3'd1);

    // R8
    p_vec_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 2'd3 && prog_addr >= VEC_LO &&
         prog_addr <= VEC_HI && prog_addr <= PROG_TOP)
        |=> trap_cause == 3'd4);

    // R10
    p_req_matches_cause_r10: assert property (@(posedge clk) disable iff (rst)
        trap_req == (trap_cause != 3'd0));

    // R10
    p_cause_legal_r10: assert property (@(posedge clk) disable iff (rst)
        trap_cause <= 3'd4);
endmodule

bind addr_fault_detect addr_fault_check #(
    .DW(DW), .PW(PW), .PROG_TOP(PROG_TOP), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
) u_fault_check (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .acc_kind   (acc_kind),
    .acc_word   (acc_word),
    .data_addr  (data_addr),
    .prog_addr  (prog_addr),
    .trap_req   (trap_req),
    .trap_cause (trap_cause)
);

// File: tb/test_addr_fault_detect.sv
`timescale 1ns/1ps
module test_addr_fault_detect;
    localparam int unsigned   DW       = 6;
    localparam int unsigned   PW       = 7;
    localparam logic [DW-1:0] DATA_TOP = 6'h2F;
    localparam logic [DW-1:0] X_LO     = 6'h10;
    localparam logic [DW-1:0] X_HI     = 6'h1F;
    localparam logic [DW-1:0] Y_LO     = 6'h20;
    localparam logic [DW-1:0] Y_HI     = 6'h2F;
    localparam logic [PW-1:0] PROG_TOP = 7'h5F;
    localparam logic [PW-1:0] VEC_LO   = 7'h04;
    localparam logic [PW-1:0] VEC_HI   = 7'h0F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    acc_kind = 2'd0;
    logic          acc_word = 1'b0;
    logic [DW-1:0] data_addr = '0;
    logic          mac_mode = 1'b0;
    logic          mac_sel_y = 1'b0;
    logic [PW-1:0] prog_addr = '0;
    logic          trap_req;
    logic [2:0]    trap_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    addr_fault_detect #(
        .DW(DW), .PW(PW), .DATA_TOP(DATA_TOP),
        .X_LO(X_LO), .X_HI(X_HI), .Y_LO(Y_LO), .Y_HI(Y_HI),
        .PROG_TOP(PROG_TOP), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
    ) i_addr_fault_detect (
        .clk(clk), .rst(rst), .req_valid(req_valid), .acc_kind(acc_kind),
        .acc_word(acc_word), .data_addr(data_addr), .mac_mode(mac_mode),
        .mac_sel_y(mac_sel_y), .prog_addr(prog_addr),
        .trap_req(trap_req), .trap_cause(trap_cause)
    );

    function automatic int model(int kind, int word, int da, int mac, int sy, int pa);
        if (kind < 2) begin
            if (word == 1 && (da % 2) == 1) return 1;
            if (da > int'(DATA_TOP)) return 2;
            if (mac == 1 && sy == 0 && da >= int'(Y_LO) && da <= int'(Y_HI)) return 2;
            if (mac == 1 && sy == 1 && da >= int'(X_LO) && da <= int'(X_HI)) return 2;
            return 0;
        end
        if (pa > int'(PROG_TOP)) return 3;
        if (kind == 3 && pa >= int'(VEC_LO) && pa <= int'(VEC_HI)) return 4;
        return 0;
    endfunction

    function automatic string tag_of(int exp, int kind, int mac);
        case (exp)
            1: return "R3";
            2: return (mac == 1) ? "R6" : "R5";
            3: return "R7";
            4: return "R8";
            default: return (kind < 2) ? "R4" : "R8";
        endcase
    endfunction

    task automatic check_out(string tag, int exp);
        checks++;
        if (int'(trap_cause) != exp) begin
            fails++;
            $display("FAIL %s cause actual=%0d expected=%0d", tag, trap_cause, exp);
        end
        checks++;
        if (trap_req != (exp != 0)) begin
            fails++;
            $display("FAIL R10 trap_req actual=%0b expected=%0b (%s)",
                     trap_req, exp != 0, tag);
        end
    endtask

    task automatic apply(int kind, int word, int da, int mac, int sy, int pa);
        @(negedge clk);
        req_valid = 1'b1;
        acc_kind  = 2'(kind);
        acc_word  = word[0];
        data_addr = DW'(da);
        mac_mode  = mac[0];
        mac_sel_y = sy[0];
        prog_addr = PW'(pa);
        @(posedge clk);
        #1;
    endtask

    task automatic run(string tag, int kind, int word, int da, int mac, int sy, int pa);
        apply(kind, word, da, mac, sy, pa);
        check_out(tag, model(kind, word, da, mac, sy, pa));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_out("R1", 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: idle cycle after a faulting request returns outputs to quiet
        run("R3", 0, 1, 5, 0, 0, 0);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check_out("R2", 0);

        // Data sweep: R3 R4 R5 R6 R9, prog_addr ignored (R10)
        for (int k = 0; k < 2; k++)
            for (int w = 0; w < 2; w++)
                for (int m = 0; m < 2; m++)
                    for (int s = 0; s < 2; s++)
                        for (int a = 0; a < 64; a++) begin
                            int e;
                            e = model(k, w, a, m, s, 7'h7F);
                            apply(k, w, a, m, s, 7'h7F);
                            check_out(tag_of(e, k, m), e);
                        end

        // Program sweep: R7 R8, data_addr ignored (R10)
        for (int k = 2; k < 4; k++)
            for (int a = 0; a < 128; a++) begin
                int e;
                e = model(k, 1, 6'h3F, 1, 0, a);
                apply(k, 1, 6'h3F, 1, 0, a);
                check_out(tag_of(e, k, 0), e);
            end

        // R9: odd word address above the top reports misaligned first
        run("R9", 1, 1, 6'h3B, 0, 0, 0);
        // R9: odd word in the wrong bank reports misaligned first
        run("R9", 0, 1, 6'h21, 1, 0, 0);

        // R1: reset mid-stream clears a pending fault
        apply(0, 1, 3, 0, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_out("R1", 0);
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule